// File: doc/BRIEF.md
# Write-Merging Memory Write Queue

This block is the pending-write buffer of a memory controller. Each pending write burst is held as a start address and a byte count. When a new write arrives, the block compares its byte range with every queued entry in the same cycle. If the two ranges overlap or touch, and the combined range still fits inside one burst, the write is folded into that entry. If no entry qualifies, the write is appended at the tail as a new entry. Entries leave in arrival order through a dequeue port that feeds the memory scheduler.

A read lookup port runs alongside the queue and is purely combinational. A read hits when one buffered write spans the read's whole byte range, so the read can be serviced from the queue. The block keeps running counts of merged writes, appended writes and read hits.

Top module: `write_merge_queue`

## Requirements
- R1: No entry ever holds more than BURST bytes, and none holds zero bytes. A combined range longer than BURST is never formed; such a write is appended instead.
- R2: An accepted write changes at most one entry. When several entries qualify, the oldest one (lowest position from the head) takes the write.
- R3: If an entry starts at or after the write's start and ends at or before the write's end, that entry's address and size become the write's address and size.
- R4: If an entry starts at or after the write's start, the write's end reaches the entry's start, and the span from the write's start to the entry's end is at most BURST, then the entry's address becomes the write's start. Its end is kept.
- R5: If an entry starts before the write and ends at or beyond the write's end, the write is absorbed and the entry is left unchanged. The merge counter still counts it.
- R6: If an entry starts before the write, its end reaches the write's start, and the span from the entry's start to the write's end is at most BURST, then the entry keeps its start and its end becomes the write's end.
- R7: Ranges that only touch (one range's end address equals the other's start) are treated as mergeable on either side.
- R8: A write that merges nowhere is appended at the tail, and entries are dequeued in arrival order. wr_ready is low only when all DEPTH entries are valid, the write would not merge, and no dequeue happens in the same cycle. A head entry that is offered but not taken stays offered.
- R9: A write that would merge is accepted even when the queue is full.
- R10: rd_hit is high when rd_req is high and some valid entry has start <= rd_addr and rd_addr+rd_size <= entry end. Each cycle with rd_hit high adds one to hit_count in the following cycle.
- R11: Each accepted merge adds one to merge_count, and each accepted append adds one to append_count. The update appears in the cycle after the write is accepted.
- R12: When a dequeue and a write are accepted in the same cycle, the write never merges into the head entry that is leaving.
- R13: After reset the queue is empty, deq_valid is low, wr_ready is high and all three counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request can be taken this cycle |
| wr_addr | input | AW | Write start byte address |
| wr_size | input | SW | Write byte count, 1..BURST |
| deq_valid | output | 1 | Head entry present |
| deq_ready | input | 1 | Scheduler takes the head entry |
| deq_addr | output | AW | Head entry start address |
| deq_size | output | SW | Head entry byte count |
| rd_req | input | 1 | Read lookup present |
| rd_addr | input | AW | Read start byte address |
| rd_size | input | SW | Read byte count |
| rd_hit | output | 1 | Read fully covered by one queued write |
| merge_count | output | CW | Writes folded into an existing entry |
| append_count | output | CW | Writes added as new entries |
| hit_count | output | CW | Read lookups that hit |

## Verification
The bench targets the boundary cases of the merge rules. It drives writes that touch entries exactly at either end, which a strict comparison would append instead of merge. It drives merges that reach exactly BURST bytes, and merges one byte beyond it; an off-by-one cap would either reject the first or build an oversized entry. It drives a write that qualifies for two entries, where a wrong priority grows the younger one. It drives a write that would grow the head in the same cycle the head is dequeued; merging there would silently lose the write. It also tests a full queue with a merging write and with a non-merging write, which catches a ready signal that ignores merges. Read lookups are aimed one byte past an entry's end and one byte before its start, to catch containment checks that accept partial overlap.

// File: rtl/write_merge_queue.sv
module write_merge_queue #(
  parameter int AW    = 16,
  parameter int BURST = 64,
  parameter int DEPTH = 8,
  parameter int CW    = 16,
  localparam int SW   = $clog2(BURST) + 1,
  localparam int NW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [SW-1:0] wr_size,
  output logic          deq_valid,
  input  logic          deq_ready,
  output logic [AW-1:0] deq_addr,
  output logic [SW-1:0] deq_size,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic [SW-1:0] rd_size,
  output logic          rd_hit,
  output logic [CW-1:0] merge_count,
  output logic [CW-1:0] append_count,
  output logic [CW-1:0] hit_count
);

  localparam logic [AW:0]   CAP  = (AW+1)'(BURST);
  localparam logic [NW-1:0] FULL = NW'(DEPTH);

  logic [AW-1:0] ent_a [DEPTH+1];
  logic [SW-1:0] ent_s [DEPTH+1];
  logic [AW-1:0] nxt_a [DEPTH+1];
  logic [SW-1:0] nxt_s [DEPTH+1];
  logic [AW-1:0] mod_a [DEPTH+1];
  logic [SW-1:0] mod_s [DEPTH+1];
  logic [NW-1:0] cnt;

  logic [DEPTH-1:0] cand, rmatch;
  logic [AW-1:0]    cand_a [DEPTH];
  logic [SW-1:0]    cand_s [DEPTH];

  logic          found;
  logic [IW-1:0] midx;
  logic [AW-1:0] m_a;
  logic [SW-1:0] m_s;

  wire deq_fire = deq_ready && (cnt != '0);
  assign deq_valid = (cnt != '0);
  assign deq_addr  = ent_a[0];
  assign deq_size  = ent_s[0];

  wire [AW:0] n_lo = {1'b0, wr_addr};
  wire [AW:0] n_hi = n_lo + {{(AW+1-SW){1'b0}}, wr_size};
  wire [AW:0] r_lo = {1'b0, rd_addr};
  wire [AW:0] r_hi = r_lo + {{(AW+1-SW){1'b0}}, rd_size};

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    wire [AW:0] e_lo = {1'b0, ent_a[i]};
    wire [AW:0] e_hi = e_lo + {{(AW+1-SW){1'b0}}, ent_s[i]};
    wire        held = NW'(i) < cnt;
    wire        live = held && !(i == 0 && deq_fire);
    logic       ok;
    logic [AW-1:0] a;
    logic [SW-1:0] s;

    always_comb begin
      ok = 1'b0;
      a  = ent_a[i];
      s  = ent_s[i];
      if (e_lo >= n_lo) begin
        if (n_hi >= e_hi) begin
          ok = 1'b1;
          a  = wr_addr;
          s  = wr_size;
        end else if (n_hi >= e_lo && (e_hi - n_lo) <= CAP) begin
          ok = 1'b1;
          a  = wr_addr;
          s  = SW'(e_hi - n_lo);
        end
      end else begin
        if (e_hi >= n_hi) begin
          ok = 1'b1;
        end else if (e_hi >= n_lo && (n_hi - e_lo) <= CAP) begin
          ok = 1'b1;
          s  = SW'(n_hi - e_lo);
        end
      end
    end

    assign cand[i]   = ok && live;
    assign cand_a[i] = a;
    assign cand_s[i] = s;
    assign rmatch[i] = held && (e_lo <= r_lo) && (r_hi <= e_hi);
  end

  always_comb begin
    found = 1'b0;
    midx  = '0;
    m_a   = wr_addr;
    m_s   = wr_size;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        midx  = IW'(i);
        m_a   = cand_a[i];
        m_s   = cand_s[i];
      end
    end
  end

  assign wr_ready = (cnt < FULL) || found || deq_fire;
  wire wr_fire  = wr_valid && wr_ready;
  wire mrg_fire = wr_fire && found;
  wire app_fire = wr_fire && !found;

  assign rd_hit = rd_req && (|rmatch);

  always_comb begin
    for (int j = 0; j <= DEPTH; j++) begin
      mod_a[j] = ent_a[j];
      mod_s[j] = ent_s[j];
      if (mrg_fire && int'(midx) == j) begin
        mod_a[j] = m_a;
        mod_s[j] = m_s;
      end
      if (app_fire && int'(cnt) == j) begin
        mod_a[j] = wr_addr;
        mod_s[j] = wr_size;
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      nxt_a[i] = deq_fire ? mod_a[i+1] : mod_a[i];
      nxt_s[i] = deq_fire ? mod_s[i+1] : mod_s[i];
    end
    nxt_a[DEPTH] = '0;
    nxt_s[DEPTH] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= DEPTH; i++) begin
        ent_a[i] <= '0;
        ent_s[i] <= '0;
      end
      cnt          <= '0;
      merge_count  <= '0;
      append_count <= '0;
      hit_count    <= '0;
    end else begin
      for (int i = 0; i <= DEPTH; i++) begin
        ent_a[i] <= nxt_a[i];
        ent_s[i] <= nxt_s[i];
      end
      cnt <= cnt + NW'(app_fire) - NW'(deq_fire);
      if (mrg_fire) merge_count  <= merge_count + CW'(1);
      if (app_fire) append_count <= append_count + CW'(1);
      if (rd_hit)   hit_count    <= hit_count + CW'(1);
    end
  end

  assert_size_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> (deq_size != '0 && deq_size <= SW'(BURST)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> (cnt == FULL && !deq_ready));

  assert_head_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !deq_ready) |=> deq_valid);

  assert_append_grow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (app_fire && !deq_fire) |=> (cnt == $past(cnt) + NW'(1) &&
                                 append_count == $past(append_count) + CW'(1)));

  assert_merge_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mrg_fire |=> (merge_count == $past(merge_count) + CW'(1) &&
                  append_count == $past(append_count)));

  assert_hit_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> hit_count == $past(hit_count) + CW'(1));

  assert_hit_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> rd_req);

endmodule

// File: tb/write_merge_queue_tb.sv
module write_merge_queue_tb;
  localparam int AW = 16, BURST = 64, DEPTH = 8, CW = 16;
  localparam int SW = $clog2(BURST) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, deq_ready = 1'b0, rd_req = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [SW-1:0] wr_size = '0, rd_size = '0;
  logic wr_ready, deq_valid, rd_hit;
  logic [AW-1:0] deq_addr;
  logic [SW-1:0] deq_size;
  logic [CW-1:0] merge_count, append_count, hit_count;

  always #5 clk = ~clk;

  write_merge_queue #(.AW(AW), .BURST(BURST), .DEPTH(DEPTH), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_size(wr_size),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_addr(deq_addr), .deq_size(deq_size),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_hit(rd_hit),
    .merge_count(merge_count), .append_count(append_count), .hit_count(hit_count));

  int vecs = 0, miss = 0;
  int mq_a [DEPTH+1];
  int mq_s [DEPTH+1];
  int mq_n = 0, m_merge = 0, m_app = 0, m_hit = 0;

  task automatic chk(input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic find_merge(input int na, input int ns, input bit skip0,
                            output int idx, output int oa, output int os);
    int ne;
    ne = na + ns;
    idx = -1; oa = 0; os = 0;
    for (int k = 0; k < mq_n; k++) begin
      int ea, ee;
      ea = mq_a[k]; ee = mq_a[k] + mq_s[k];
      if (idx < 0 && !(skip0 && k == 0)) begin
        if (ea >= na) begin
          if (ne >= ee) begin idx = k; oa = na; os = ns; end
          else if (ne >= ea && ee - na <= BURST) begin idx = k; oa = na; os = ee - na; end
        end else begin
          if (ee >= ne) begin idx = k; oa = ea; os = mq_s[k]; end
          else if (ee >= na && ne - ea <= BURST) begin idx = k; oa = ea; os = ne - ea; end
        end
      end
    end
  endtask

  task automatic step(input bit wv, input int wa, input int ws, input bit dr,
                      input bit rq, input int ra, input int rs, input string tag);
    bit deqf, rdy, hit;
    int k, oa, os;
    @(negedge clk);
    wr_valid = wv; wr_addr = AW'(wa); wr_size = SW'(ws);
    deq_ready = dr; rd_req = rq; rd_addr = AW'(ra); rd_size = SW'(rs);
    #2;
    deqf = dr && mq_n > 0;
    find_merge(wa, ws, deqf, k, oa, os);
    rdy = (mq_n < DEPTH) || (k >= 0) || deqf;
    hit = 1'b0;
    for (int i = 0; i < mq_n; i++)
      if (rq && mq_a[i] <= ra && ra + rs <= mq_a[i] + mq_s[i]) hit = 1'b1;
    chk({"wr_ready R8 R9 ", tag}, int'(wr_ready), int'(rdy));
    chk({"deq_valid R8 ", tag}, int'(deq_valid), int'(mq_n > 0));
    if (mq_n > 0) begin
      chk({"deq_addr R8 ", tag}, int'(deq_addr), mq_a[0]);
      chk({"deq_size R1 ", tag}, int'(deq_size), mq_s[0]);
    end
    chk({"rd_hit R10 ", tag}, int'(rd_hit), int'(hit));
    chk({"merge_count R11 ", tag}, int'(merge_count), m_merge);
    chk({"append_count R11 ", tag}, int'(append_count), m_app);
    chk({"hit_count R10 ", tag}, int'(hit_count), m_hit);
    if (wv && rdy) begin
      if (k >= 0) begin mq_a[k] = oa; mq_s[k] = os; m_merge++; end
      else begin mq_a[mq_n] = wa; mq_s[mq_n] = ws; mq_n++; m_app++; end
    end
    if (hit) m_hit++;
    if (deqf) begin
      for (int i = 0; i < mq_n - 1; i++) begin mq_a[i] = mq_a[i+1]; mq_s[i] = mq_s[i+1]; end
      mq_n--;
    end
  endtask

  task automatic wr(input int a, input int s, input string tag);
    step(1'b1, a, s, 1'b0, 1'b0, 0, 1, tag);
  endtask

  task automatic drain(input string tag);
    while (mq_n > 0) step(1'b0, 0, 1, 1'b1, 1'b0, 0, 1, tag);
    step(1'b0, 0, 1, 1'b0, 1'b0, 0, 1, tag);
  endtask

  task automatic rd(input int a, input int s, input string tag);
    step(1'b0, 0, 1, 1'b0, 1'b1, a, s, tag);
  endtask

  initial begin
    #1_000_000;
    miss++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("reset wr_ready R13", int'(wr_ready), 1);
    chk("reset deq_valid R13", int'(deq_valid), 0);
    chk("reset counters R13", int'(merge_count) + int'(append_count) + int'(hit_count), 0);

    wr(100, 8, "R3"); wr(96, 20, "R3"); drain("R3");
    wr(200, 10, "R4"); wr(195, 8, "R4"); drain("R4");
    wr(300, 20, "R5"); wr(305, 5, "R5"); drain("R5");
    wr(400, 10, "R6"); wr(405, 20, "R6"); drain("R6");
    wr(500, 8, "R7"); wr(508, 8, "R7"); wr(492, 8, "R7"); drain("R7");
    wr(600, 60, "R1"); wr(660, 10, "R1"); drain("R1");
    wr(700, 32, "R1"); wr(732, 32, "R1"); wr(764, 1, "R1"); drain("R1");
    wr(1000, 8, "R2"); wr(1010, 8, "R2"); wr(1008, 2, "R2"); drain("R2");
    for (int i = 0; i < DEPTH; i++) wr(2000 + 100 * i, 4, "R8");
    wr(9000, 4, "R8");
    wr(2302, 6, "R9");
    step(1'b1, 9100, 4, 1'b1, 1'b0, 0, 1, "R8");
    drain("R8");
    wr(3000, 8, "R12"); wr(3100, 8, "R12");
    step(1'b1, 3004, 8, 1'b1, 1'b0, 0, 1, "R12");
    drain("R12");
    wr(4000, 16, "R10");
    rd(4004, 8, "R10"); rd(4000, 16, "R10"); rd(4010, 8, "R10"); rd(3999, 2, "R10");
    drain("R10");

    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(9, 0) < 7, $urandom_range(400, 0), $urandom_range(BURST, 1),
           $urandom_range(9, 0) < 4, $urandom_range(1, 0) == 1,
           $urandom_range(420, 0), $urandom_range(BURST, 1), "random R2 R12");
    end
    drain("final R8");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule